// File: doc/BRIEF.md
# Direct-Mapped Branch Target Predictor

This block sits beside instruction fetch and guesses the address of the next instruction. The fetch address is looked up in a direct-mapped table. Each entry keeps a valid flag, the upper bits of the word address as a tag, a word-aligned target, and two history bits. The history bits are a taken/not-taken guess and a flag that records whether the last guess for that entry was right. A tag hit whose guess is "taken" steers fetch to the stored target. Any other lookup steers fetch to the sequential address, the fetch address plus four.

When a branch resolves in execute, the pipeline sends back four things: the branch address, the real outcome, the real target, and the next-PC that fetch used for the instruction after that branch. The block rewrites the entry with this information. One clock later it raises a flush pulse if the real next address differs from the one that was used, and it supplies the corrected address with that pulse. The history rule is deliberately slow to change: a single miss only clears the "last right" flag, and the guess flips only on a second miss in a row. A loop-closing branch therefore keeps predicting "taken" after its one exit.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid. The first lookup after reset reports `pred_hit`=0, and `flush` stays 0 while no update is presented.
- R2: Entry index is `pc[IDX_W+1:2]` and tag is `pc[ADDR_W-1:IDX_W+2]`. A lookup hits only on a valid entry whose stored tag equals the tag of the fetch address.
- R3: One clock after `fetch_pc` is presented, the lookup outputs are valid. `pred_taken` is 1 only on a hit whose guess bit is 1, and in that case `pred_npc` is the stored target (low two bits 0). In every other case `pred_npc` is `{fetch_pc[ADDR_W-1:2]+1, 2'b00}`.
- R4: An update whose tag misses the indexed entry allocates it. The new tag and target are written, and the history starts at guess=0, last-right=1 before the outcome is applied. So one taken update on a fresh entry leaves it predicting not-taken.
- R5: When the entry's guess bit equals the resolved outcome, the guess is kept and last-right becomes 1.
- R6: When the guess is wrong and last-right is 1, the guess is kept and last-right becomes 0.
- R7: When the guess is wrong and last-right is 0, the guess flips and last-right becomes 1.
- R8: One clock after an update, `flush` is 1 exactly when the real next address differs from `upd_pred_npc`. The real next address is `upd_target` (low bits cleared) if taken, or `upd_pc`+4 if not taken. `flush_pc` carries the real next address with the pulse.
- R9: When a lookup and an update address the same entry in one cycle, the lookup returns the contents from before that update.
- R10: An update to the same index with a different tag replaces the entry, so the earlier address then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | ADDR_W | Address being fetched |
| pred_hit | output | 1 | Lookup matched a valid entry |
| pred_taken | output | 1 | Lookup predicts taken |
| pred_npc | output | ADDR_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_target | input | ADDR_W | Resolved branch target |
| upd_pred_npc | input | ADDR_W | Next address fetch used after this branch |
| flush | output | 1 | Prediction was wrong; younger instructions must be killed |
| flush_pc | output | ADDR_W | Correct next address, valid with `flush` |

## Verification
Both result paths have a latency of one clock. The lookup outputs follow `fetch_pc` by one edge, and `flush`/`flush_pc` follow an update by one edge. An update becomes visible to lookups made on the edge after it is written, never on the edge where it is written. The bench drives each stimulus on a falling edge and advances its behavioural table model at that moment, after it has taken the expected lookup from the old model contents. It then samples all outputs on the following falling edge, which is exactly one rising edge later.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef struct packed {
    logic guess;   // 1 = predict taken
    logic right;   // last guess for this entry was correct
  } hist_t;

  localparam hist_t HIST_INIT = '{guess: 1'b0, right: 1'b1};
endpackage

// File: rtl/btb_history.sv
module btb_history
  import btb_pkg::*;
(
  input  logic  hit,
  input  hist_t cur,
  input  logic  taken,
  output hist_t nxt
);
  hist_t base;

  always_comb begin
    base = hit ? cur : HIST_INIT;
    if (base.guess == taken) begin
      nxt = '{guess: base.guess, right: 1'b1};
    end else if (!base.right) begin
      nxt = '{guess: ~base.guess, right: 1'b1};
    end else begin
      nxt = '{guess: base.guess, right: 1'b0};
    end
  end
endmodule

// File: rtl/btb_table.sv
module btb_table
  import btb_pkg::*;
#(
  parameter int IDX_W = 12,
  parameter int TAG_W = 18,
  parameter int TGT_W = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [TGT_W-1:0] rd_tgt,
  output hist_t            rd_hist,
  input  logic [IDX_W-1:0] ua_idx,
  output logic             ua_valid,
  output logic [TAG_W-1:0] ua_tag,
  output hist_t            ua_hist,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [TAG_W-1:0] w_tag,
  input  logic [TGT_W-1:0] w_tgt,
  input  hist_t            w_hist
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem  [DEPTH];
  logic [TGT_W-1:0] tgt_mem  [DEPTH];
  hist_t            hist_mem [DEPTH];
  logic [DEPTH-1:0] valid_q;

  // memory write plus read-first registered lookup port
  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[w_idx]  <= w_tag;
      tgt_mem[w_idx]  <= w_tgt;
      hist_mem[w_idx] <= w_hist;
    end
    rd_tag  <= tag_mem[rd_idx];
    rd_tgt  <= tgt_mem[rd_idx];
    rd_hist <= hist_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (we) valid_q[w_idx] <= 1'b1;
      rd_valid <= valid_q[rd_idx];
    end
  end

  // asynchronous update-side read
  assign ua_valid = valid_q[ua_idx];
  assign ua_tag   = tag_mem[ua_idx];
  assign ua_hist  = hist_mem[ua_idx];
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_npc,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic [ADDR_W-1:0] upd_pred_npc,
  output logic              flush,
  output logic [ADDR_W-1:0] flush_pc
);
  localparam int WA_W  = ADDR_W - 2;
  localparam int TAG_W = WA_W - IDX_W;

  logic [WA_W-1:0]  f_wa, u_wa, pc_q;
  logic             rd_valid, ua_valid, u_hit;
  logic [TAG_W-1:0] rd_tag, ua_tag;
  logic [WA_W-1:0]  rd_tgt;
  hist_t            rd_hist, ua_hist, nxt_hist;
  logic [ADDR_W-1:0] real_npc;

  assign f_wa = fetch_pc[ADDR_W-1:2];
  assign u_wa = upd_pc[ADDR_W-1:2];

  btb_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(WA_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (f_wa[IDX_W-1:0]),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_tgt   (rd_tgt),
    .rd_hist  (rd_hist),
    .ua_idx   (u_wa[IDX_W-1:0]),
    .ua_valid (ua_valid),
    .ua_tag   (ua_tag),
    .ua_hist  (ua_hist),
    .we       (upd_valid),
    .w_idx    (u_wa[IDX_W-1:0]),
    .w_tag    (u_wa[WA_W-1:IDX_W]),
    .w_tgt    (upd_target[ADDR_W-1:2]),
    .w_hist   (nxt_hist)
  );

  assign u_hit = ua_valid && (ua_tag == u_wa[WA_W-1:IDX_W]);

  btb_history u_hist (
    .hit   (u_hit),
    .cur   (ua_hist),
    .taken (upd_taken),
    .nxt   (nxt_hist)
  );

  // lookup side: address registered alongside the synchronous table read
  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= f_wa;
  end

  assign pred_hit   = rd_valid && (rd_tag == pc_q[WA_W-1:IDX_W]);
  assign pred_taken = pred_hit && rd_hist.guess;
  assign pred_npc   = pred_taken ? {rd_tgt, 2'b00} : {pc_q + WA_W'(1), 2'b00};

  // resolve side
  assign real_npc = upd_taken ? {upd_target[ADDR_W-1:2], 2'b00}
                              : {u_wa + WA_W'(1), 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      flush    <= 1'b0;
      flush_pc <= '0;
    end else begin
      flush    <= upd_valid && (real_npc != upd_pred_npc);
      flush_pc <= real_npc;
    end
  end

  // R1
  reset_miss_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pred_hit);

  // R3
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> pred_hit);

  // R3
  seq_npc_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !pred_taken |->
      pred_npc == {$past(fetch_pc[ADDR_W-1:2]) + WA_W'(1), 2'b00});

  // R8
  flush_src_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> $past(upd_valid));

  // R6
  first_miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
    upd_valid && u_hit && ua_hist.right |-> nxt_hist.guess == ua_hist.guess);
endmodule

// File: tb/btb_predictor_bench.sv
`timescale 1ns/1ps
module btb_predictor_bench;
  localparam int AW = 32;
  localparam int IW = 4;
  localparam int N  = 1 << IW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] fetch_pc, upd_pc, upd_target, upd_pred_npc, pred_npc, flush_pc;
  logic          upd_valid, upd_taken, pred_hit, pred_taken, flush;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // behavioural table model
  bit          m_v   [N];
  int unsigned m_tag [N];
  logic [AW-1:0] m_tgt [N];
  bit          m_g   [N];
  bit          m_r   [N];

  always #10 clk = ~clk;  // 50 MHz

  btb_predictor #(.ADDR_W(AW), .IDX_W(IW)) u_btb_predictor (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .pred_npc(pred_npc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_pred_npc(upd_pred_npc),
    .flush(flush), .flush_pc(flush_pc)
  );

  task automatic chk(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, logic [AW-1:0] fpc, bit uv, logic [AW-1:0] upc,
                      bit utk, logic [AW-1:0] utgt, logic [AW-1:0] upred);
    int fi, ui;
    bit e_hit, e_tk, e_fl, uh, g, r;
    logic [AW-1:0] e_npc, act;
    fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_taken = utk;
    upd_target = utgt; upd_pred_npc = upred;
    fi = int'(fpc[IW+1:2]);
    e_hit = m_v[fi] && (m_tag[fi] == 32'(fpc[AW-1:IW+2]));
    e_tk  = e_hit && m_g[fi];
    e_npc = e_tk ? m_tgt[fi] : {fpc[AW-1:2] + 30'd1, 2'b00};
    act   = utk ? {utgt[AW-1:2], 2'b00} : {upc[AW-1:2] + 30'd1, 2'b00};
    e_fl  = uv && (act != upred);
    if (uv) begin
      ui = int'(upc[IW+1:2]);
      uh = m_v[ui] && (m_tag[ui] == 32'(upc[AW-1:IW+2]));
      g = uh ? m_g[ui] : 1'b0;
      r = uh ? m_r[ui] : 1'b1;
      if (g == utk) r = 1'b1;
      else if (!r) begin g = ~g; r = 1'b1; end
      else r = 1'b0;
      m_v[ui] = 1'b1; m_tag[ui] = 32'(upc[AW-1:IW+2]);
      m_tgt[ui] = {utgt[AW-1:2], 2'b00}; m_g[ui] = g; m_r[ui] = r;
    end
    @(posedge clk);
    @(negedge clk);
    chk(req, "pred_hit", AW'(pred_hit), AW'(e_hit));
    chk(req, "pred_taken", AW'(pred_taken), AW'(e_tk));
    chk(req, "pred_npc", pred_npc, e_npc);
    chk(req, "flush", AW'(flush), AW'(e_fl));
    if (e_fl) chk(req, "flush_pc", flush_pc, act);
  endtask

  localparam logic [AW-1:0] PA = 32'h0000_1040;  // index 0
  localparam logic [AW-1:0] PB = 32'h0000_2040;  // index 0, other tag
  localparam logic [AW-1:0] PC = 32'h0000_1044;  // index 1
  localparam logic [AW-1:0] T1 = 32'h0000_8000;
  localparam logic [AW-1:0] T2 = 32'h0000_9000;

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_tag[i] = 0; m_tgt[i] = '0; m_g[i] = 0; m_r[i] = 1;
    end
    rst = 1'b1; fetch_pc = PA; upd_valid = 0; upd_pc = '0; upd_taken = 0;
    upd_target = '0; upd_pred_npc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    step("R1", PA, 0, '0, 0, '0, '0);
    step("R1", PC, 0, '0, 0, '0, '0);
    // R4: fresh taken update flushes and stays not-taken; R8 flush
    step("R8", PC, 1, PA, 1, T1, PA + 4);
    step("R4", PA, 0, '0, 0, '0, '0);
    // R7: second miss flips guess
    step("R7", PC, 1, PA, 1, T1, PA + 4);
    step("R3", PA, 0, '0, 0, '0, '0);
    // R5: correct guess, no flush
    step("R5", PC, 1, PA, 1, T1, T1);
    // R6: one not-taken exit keeps taken guess
    step("R6", PC, 1, PA, 0, T1, T1);
    step("R6", PA, 0, '0, 0, '0, '0);
    // R8: right direction, wrong target
    step("R8", PC, 1, PA, 1, T2, T1);
    // R6 then R7: two misses in a row; R9 same-cycle lookup sees old
    step("R6", PC, 1, PA, 0, T2, T2);
    step("R9", PA, 1, PA, 0, T2, T2);
    step("R7", PA, 0, '0, 0, '0, '0);
    // R2 / R10: alias at same index
    step("R2", PB, 0, '0, 0, '0, '0);
    step("R10", PC, 1, PB, 1, T2, PB + 4);
    step("R10", PA, 0, '0, 0, '0, '0);
    step("R2", PB, 0, '0, 0, '0, '0);
    step("R5", PC, 1, PC, 0, T1, PC + 4);
    step("R3", PC, 0, '0, 0, '0, '0);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule